// File: doc/BRIEF.md
# Transmit Timestamp Slot Tracker

This block manages the pool of hardware timestamp slots that one port uses for outgoing packets that ask for a transmit timestamp. Every transmit queue of the port draws from the same pool. A requester presents a tag. One cycle later the block returns either a grant with the slot index, or a skip pulse when it cannot hand out a slot. The index is carried in the transmit descriptor. When the captured timestamp for that index has been read, the completion input names the index. The block then returns the index, the original tag and a flag that says whether the result must be thrown away.

Ports are grouped four to a quad, and the four ports of a quad share one slot memory. Each port therefore owns a separate window of that memory, starting at `(PORT_ID mod 4) * SLOTS`.

A bulk stale command poisons every slot that is in flight, so results captured against an outdated clock are discarded when they complete. Slots that never complete are reclaimed by a per-slot age limit. A teardown flush empties the whole pool. A sequential allocation mode hands out slots strictly in order, so completions return first-in first-out. Three counters record refused requests, timeouts and flushed slots.

Top module: `tx_ts_tracker`

## Requirements
- R1: While and after reset, no slot is in use, `grant_vld`, `skip` and `rpt_vld` are low, and all three counters read zero.
- R2: A request with `req_vld` high is answered on the next clock edge by exactly one of `grant_vld` or `skip`. A granted index is `(PORT_ID mod 4)*SLOTS + slot`, where `slot` is in the range 0 to SLOTS-1.
- R3: With `ll_mode` low, a grant takes the lowest-numbered free slot.
- R4: A slot in use is never granted again. A request refused for any reason pulses `skip` and increments `cnt_skip` by one.
- R5: A completion whose index names an in-use slot of this port produces, on the next edge, `rpt_vld` with that index, the tag stored at grant time, and `rpt_stale`, where 1 means drop. The slot becomes free at the same edge.
- R6: A completion that names a free slot, or an index outside this port's window, produces no report and changes no slot.
- R7: `stale_all` sets the stale mark of every slot in use at that edge. A newly granted slot always starts with its mark clear.
- R8: With `ll_mode` high, grants follow a pointer that starts at slot 0, advances by one per grant and wraps at SLOTS-1. If the pointed slot is in use, the request is skipped even when other slots are free.
- R9: Slot age advances once every TICK_DIV cycles. When a slot's age reaches `tmo_limit`, the slot is freed without a report and `cnt_tmo` increments.
- R10: While `flush` is high, every in-use slot is freed, `cnt_flush` grows by the number of slots freed, completions are ignored, requests are skipped, and the sequential pointer returns to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_mode | input | 1 | 1 selects sequential (FIFO-order) allocation |
| tmo_limit | input | AGE_W | Age in ticks at which an outstanding slot is reclaimed |
| req_vld | input | 1 | Slot request |
| req_tag | input | TAG_W | Tag stored with the granted slot |
| grant_vld | output | 1 | Request granted |
| grant_idx | output | clog2(4*SLOTS) | Granted slot index in quad memory |
| skip | output | 1 | Request refused |
| cmpl_vld | input | 1 | Timestamp for `cmpl_idx` has been read |
| cmpl_idx | input | clog2(4*SLOTS) | Completed index in quad memory |
| rpt_vld | output | 1 | Completion report |
| rpt_idx | output | clog2(4*SLOTS) | Reported index |
| rpt_stale | output | 1 | 1: discard this timestamp |
| rpt_tag | output | TAG_W | Tag of the completed request |
| stale_all | input | 1 | Mark all outstanding slots stale |
| flush | input | 1 | Teardown: free every slot, refuse requests |
| cnt_skip | output | CNT_W | Refused request count |
| cnt_tmo | output | CNT_W | Timed-out slot count |
| cnt_flush | output | CNT_W | Flushed slot count |

## Verification
The bench builds the tracker with SLOTS=4 and PORT_ID=5, so the port window starts at index 4. With only four slots, pool exhaustion, pointer wrap and out-of-window completions below the base can all be reached in a few cycles. TICK_DIV=4 and AGE_W=4 let a limit of 3 ticks expire within about a dozen cycles. These values allow the timeout to be bracketed by one check just before the earliest possible expiry and one just after the latest.

// File: rtl/tx_ts_tracker.sv
module tx_ts_tracker #(
  parameter int SLOTS    = 16,
  parameter int PORT_ID  = 0,
  parameter int TAG_W    = 16,
  parameter int AGE_W    = 8,
  parameter int TICK_DIV = 1000,
  parameter int CNT_W    = 32
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ll_mode,
  input  logic [AGE_W-1:0]            tmo_limit,
  input  logic                        req_vld,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        grant_vld,
  output logic [$clog2(4*SLOTS)-1:0]  grant_idx,
  output logic                        skip,
  input  logic                        cmpl_vld,
  input  logic [$clog2(4*SLOTS)-1:0]  cmpl_idx,
  output logic                        rpt_vld,
  output logic [$clog2(4*SLOTS)-1:0]  rpt_idx,
  output logic                        rpt_stale,
  output logic [TAG_W-1:0]            rpt_tag,
  input  logic                        stale_all,
  input  logic                        flush,
  output logic [CNT_W-1:0]            cnt_skip,
  output logic [CNT_W-1:0]            cnt_tmo,
  output logic [CNT_W-1:0]            cnt_flush
);
  localparam int IDX_W  = $clog2(4*SLOTS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BASE   = (PORT_ID % 4) * SLOTS;
  localparam int PRE_W  = $clog2(TICK_DIV + 1);

  logic [SLOTS-1:0]  busy, stale, alloc_oh, cmpl_oh, expire, free_mask, busy_n, stale_n;
  logic [TAG_W-1:0]  tag_q [SLOTS];
  logic [AGE_W-1:0]  age_q [SLOTS];
  logic [SLOT_W-1:0] rr_ptr, low_slot, alloc_slot, cmpl_slot;
  logic [IDX_W-1:0]  cmpl_off;
  logic [PRE_W-1:0]  pre_q;
  logic              any_free, can_alloc, do_alloc, cmpl_hit, done_ok, tick;

  always_comb begin
    low_slot = '0;
    any_free = 1'b0;
    for (int i = SLOTS-1; i >= 0; i--)
      if (!busy[i]) begin
        low_slot = SLOT_W'(i);
        any_free = 1'b1;
      end
  end

  assign alloc_slot = ll_mode ? rr_ptr : low_slot;
  assign can_alloc  = ll_mode ? !busy[rr_ptr] : any_free;
  assign do_alloc   = req_vld && !flush && can_alloc;
  assign alloc_oh   = do_alloc ? (SLOTS'(1) << alloc_slot) : '0;

  assign cmpl_off  = cmpl_idx - IDX_W'(BASE);
  assign cmpl_slot = cmpl_off[SLOT_W-1:0];
  assign cmpl_hit  = cmpl_vld && (cmpl_idx >= IDX_W'(BASE)) && (cmpl_off < IDX_W'(SLOTS));
  assign done_ok   = cmpl_hit && busy[cmpl_slot] && !flush;
  assign cmpl_oh   = done_ok ? (SLOTS'(1) << cmpl_slot) : '0;

  assign tick = (pre_q == PRE_W'(TICK_DIV - 1));

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign expire[g] = tick && busy[g] && !cmpl_oh[g] && !flush &&
                       (({1'b0, age_q[g]} + 1'b1) >= {1'b0, tmo_limit});
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        age_q[g] <= '0;
        tag_q[g] <= '0;
      end else if (alloc_oh[g]) begin
        age_q[g] <= '0;
        tag_q[g] <= req_tag;
      end else if (tick && busy[g]) begin
        age_q[g] <= age_q[g] + 1'b1;
      end
  end

  assign free_mask = flush ? busy : (cmpl_oh | expire);
  assign busy_n    = (busy & ~free_mask) | alloc_oh;
  assign stale_n   = (stale | (busy & {SLOTS{stale_all}})) & busy_n & ~alloc_oh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= '0;
      stale     <= '0;
      rr_ptr    <= '0;
      pre_q     <= '0;
      grant_vld <= 1'b0;
      grant_idx <= '0;
      skip      <= 1'b0;
      rpt_vld   <= 1'b0;
      rpt_idx   <= '0;
      rpt_stale <= 1'b0;
      rpt_tag   <= '0;
      cnt_skip  <= '0;
      cnt_tmo   <= '0;
      cnt_flush <= '0;
    end else begin
      busy      <= busy_n;
      stale     <= stale_n;
      pre_q     <= tick ? '0 : pre_q + 1'b1;
      if (flush)
        rr_ptr <= '0;
      else if (ll_mode && do_alloc)
        rr_ptr <= (rr_ptr == SLOT_W'(SLOTS-1)) ? '0 : rr_ptr + 1'b1;
      grant_vld <= do_alloc;
      grant_idx <= IDX_W'(BASE) + IDX_W'(alloc_slot);
      skip      <= req_vld && !do_alloc;
      rpt_vld   <= done_ok;
      rpt_idx   <= cmpl_idx;
      rpt_stale <= stale[cmpl_slot];
      rpt_tag   <= tag_q[cmpl_slot];
      cnt_skip  <= cnt_skip + CNT_W'(req_vld && !do_alloc);
      cnt_tmo   <= cnt_tmo + CNT_W'($countones(expire));
      cnt_flush <= cnt_flush + (flush ? CNT_W'($countones(busy)) : '0);
    end
endmodule

// File: rtl/tx_ts_tracker_chk.sv
module tx_ts_tracker_chk #(
  parameter int SLOTS   = 16,
  parameter int PORT_ID = 0
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_vld,
  input logic                        stale_all,
  input logic                        flush,
  input logic                        grant_vld,
  input logic [$clog2(4*SLOTS)-1:0]  grant_idx,
  input logic                        skip,
  input logic                        rpt_vld,
  input logic [$clog2(4*SLOTS)-1:0]  rpt_idx,
  input logic [SLOTS-1:0]            busy,
  input logic [SLOTS-1:0]            stale
);
  localparam int IDX_W  = $clog2(4*SLOTS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BASE   = (PORT_ID % 4) * SLOTS;

  logic [IDX_W-1:0]  g_off, r_off;
  logic [SLOT_W-1:0] gslot, rslot;
  assign g_off = grant_idx - IDX_W'(BASE);
  assign r_off = rpt_idx - IDX_W'(BASE);
  assign gslot = g_off[SLOT_W-1:0];
  assign rslot = r_off[SLOT_W-1:0];

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && skip));

  p_grant_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (int'(grant_idx) >= BASE && int'(grant_idx) < BASE + SLOTS));

  p_grant_was_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ((($past(busy) >> gslot) & SLOTS'(1)) == '0));

  p_report_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |-> !busy[rslot]);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy == '0));

  p_stale_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_all && !flush && !req_vld) |=> ((busy & ~stale) == '0));
endmodule

bind tx_ts_tracker tx_ts_tracker_chk #(.SLOTS(SLOTS), .PORT_ID(PORT_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .stale_all(stale_all), .flush(flush),
  .grant_vld(grant_vld), .grant_idx(grant_idx), .skip(skip),
  .rpt_vld(rpt_vld), .rpt_idx(rpt_idx), .busy(busy), .stale(stale)
);

// File: tb/sim_tx_ts_tracker.sv
`timescale 1ns/1ps
module sim_tx_ts_tracker;
  localparam int SLOTS = 4, PORT_ID = 5, TAG_W = 8, AGE_W = 4, TICK_DIV = 4, CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, ll_mode = 1'b0;
  logic [AGE_W-1:0] tmo_limit = 4'd15;
  logic req_vld = 1'b0, cmpl_vld = 1'b0, stale_all = 1'b0, flush = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [3:0] cmpl_idx = '0;
  logic grant_vld, skip, rpt_vld, rpt_stale;
  logic [3:0] grant_idx, rpt_idx;
  logic [TAG_W-1:0] rpt_tag;
  logic [CNT_W-1:0] cnt_skip, cnt_tmo, cnt_flush;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_ts_tracker #(.SLOTS(SLOTS), .PORT_ID(PORT_ID), .TAG_W(TAG_W), .AGE_W(AGE_W),
                  .TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_mode(ll_mode), .tmo_limit(tmo_limit),
    .req_vld(req_vld), .req_tag(req_tag), .grant_vld(grant_vld), .grant_idx(grant_idx),
    .skip(skip), .cmpl_vld(cmpl_vld), .cmpl_idx(cmpl_idx), .rpt_vld(rpt_vld),
    .rpt_idx(rpt_idx), .rpt_stale(rpt_stale), .rpt_tag(rpt_tag), .stale_all(stale_all),
    .flush(flush), .cnt_skip(cnt_skip), .cnt_tmo(cnt_tmo), .cnt_flush(cnt_flush));

  // op: 0 request, 1 completion, 2 stale-all, 3 idle; kind: 0 none, 1 grant, 2 skip, 3 report
  function automatic logic [31:0] mkv(int op, int arg, int kind, int idx, int tag, int rq, int st);
    return {2'(op), 8'(arg), 2'(kind), 4'(idx), 8'(tag), 4'(rq), 3'd0, 1'(st)};
  endfunction

  localparam logic [31:0] VEC [14] = '{
    mkv(0, 'hA1, 1, 4, 0,    2, 0),  // R2 first grant at window base
    mkv(0, 'hA2, 1, 5, 0,    3, 0),  // R3
    mkv(0, 'hA3, 1, 6, 0,    3, 0),  // R3
    mkv(0, 'hA4, 1, 7, 0,    3, 0),  // R3
    mkv(0, 'hA5, 2, 0, 0,    4, 0),  // R4 pool exhausted
    mkv(1, 5,    3, 5, 'hA2, 5, 0),  // R5
    mkv(0, 'hA6, 1, 5, 0,    3, 0),  // R3 lowest free reused
    mkv(2, 0,    0, 0, 0,    7, 0),  // R7
    mkv(1, 4,    3, 4, 'hA1, 7, 1),  // R7 stale report
    mkv(0, 'hA7, 1, 4, 0,    7, 0),  // R7
    mkv(1, 4,    3, 4, 'hA7, 7, 0),  // R7 mark cleared on grant
    mkv(1, 4,    0, 0, 0,    6, 0),  // R6 free slot
    mkv(1, 2,    0, 0, 0,    6, 0),  // R6 outside window
    mkv(1, 6,    3, 6, 'hA3, 7, 1)   // R7
  };

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_vec(logic [31:0] v);
    logic [1:0] op = v[31:30];
    logic [1:0] kind = v[21:20];
    logic [15:0] act, exp;
    @(negedge clk);
    req_vld = 1'b0; cmpl_vld = 1'b0; stale_all = 1'b0;
    case (op)
      2'd0: begin req_vld = 1'b1; req_tag = v[29:22]; end
      2'd1: begin cmpl_vld = 1'b1; cmpl_idx = v[25:22]; end
      2'd2: stale_all = 1'b1;
      default: ;
    endcase
    @(posedge clk); #1;
    act = {grant_vld, skip, rpt_vld, grant_vld ? grant_idx : (rpt_vld ? rpt_idx : 4'd0),
           rpt_vld ? rpt_tag : 8'd0, rpt_vld & rpt_stale};
    exp = {kind == 2'd1, kind == 2'd2, kind == 2'd3,
           (kind == 2'd1 || kind == 2'd3) ? v[19:16] : 4'd0,
           kind == 2'd3 ? v[15:8] : 8'd0, kind == 2'd3 && v[0]};
    chk(act == exp, $sformatf("R%0d", v[7:4]), act, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0; cmpl_vld = 1'b0; stale_all = 1'b0; flush = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({grant_vld, skip, rpt_vld} == 3'b000, "R1", {grant_vld, skip, rpt_vld}, 0);
    chk({cnt_skip, cnt_tmo, cnt_flush} == '0, "R1", {cnt_skip, cnt_tmo, cnt_flush}, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 14; i++) run_vec(VEC[i]);
    chk(cnt_skip == 1, "R4", cnt_skip, 1);
    chk(cnt_tmo == 0, "R9", cnt_tmo, 0);

    // R10 flush: slots 5 and 7 outstanding, request refused
    @(negedge clk);
    cmpl_vld = 1'b0; flush = 1'b1; req_vld = 1'b1; req_tag = 8'hB0;
    @(posedge clk); #1;
    chk(skip && !grant_vld, "R10", {grant_vld, skip}, 2'b01);
    idle();
    chk(cnt_flush == 2, "R10", cnt_flush, 2);
    chk(cnt_skip == 2, "R10", cnt_skip, 2);
    run_vec(mkv(1, 7, 0, 0, 0, 10, 0));     // R10 flushed slot no longer reports
    // R9 timeout with a limit of 3 ticks
    @(negedge clk) tmo_limit = 4'd3;
    run_vec(mkv(0, 'hD1, 1, 4, 0, 10, 0));  // R10 pool empty after flush
    idle();
    repeat (7) @(posedge clk);
    #1 chk(cnt_tmo == 0, "R9", cnt_tmo, 0);
    repeat (5) @(posedge clk);
    #1 chk(cnt_tmo == 1, "R9", cnt_tmo, 1);
    run_vec(mkv(1, 4, 0, 0, 0, 9, 0));      // R9 reclaimed slot silent
    run_vec(mkv(0, 'hD2, 1, 4, 0, 9, 0));   // R9 reclaimed slot reusable
    @(negedge clk);
    req_vld = 1'b0; flush = 1'b1; tmo_limit = 4'd15;
    idle();
    chk(cnt_flush == 3, "R10", cnt_flush, 3);

    // R8 sequential allocation
    ll_mode = 1'b1;
    run_vec(mkv(0, 'hC1, 1, 4, 0,    8, 0));
    run_vec(mkv(0, 'hC2, 1, 5, 0,    8, 0));
    run_vec(mkv(1, 4,    3, 4, 'hC1, 5, 0));
    run_vec(mkv(0, 'hC3, 1, 6, 0,    8, 0));  // R8 not lowest free
    run_vec(mkv(0, 'hC4, 1, 7, 0,    8, 0));
    run_vec(mkv(0, 'hC5, 1, 4, 0,    8, 0));  // R8 wrap
    run_vec(mkv(1, 6,    3, 6, 'hC3, 5, 0));
    run_vec(mkv(0, 'hC6, 2, 0, 0,    8, 0));  // R8 pointer slot busy
    idle();
    chk(cnt_skip == 3, "R8", cnt_skip, 3);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule